// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a two-wire serial slave that lets a bus master read and write a small external register file one byte at a time. SCL and SDA are sampled by the fast system clock through a synchronizer chain, and START, STOP and clock edges are found on the synchronized values. SDA is open drain: the block only ever pulls it low, through `sda_oe`.

A write transfer carries the slave address and then a register index that loads an internal pointer. Every later byte produces a one-cycle write strobe toward the register file. A read transfer shifts out the byte that the register file presents for the current pointer. The pointer advances after every data byte in either direction and wraps at the end of the space. A repeated START brings the slave back to address matching at any point. A power-fail indication aborts whatever is in progress, clears the pointer and makes the slave deaf to the bus while it lasts.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_wr_en` is 0 and `reg_addr` is 0.
- R2: After a START (SDA falling while SCL is high), the slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h68, that is byte D0h for a write and D1h for a read, bit 0 = 1 meaning read). It acknowledges by pulling SDA low for the ninth clock. It does not acknowledge any other address, and it then keeps SDA released until the next START.
- R3: The first data byte of a write loads the pointer (`reg_addr`). A value of NUM_REGS (20) or more loads 0. The byte is acknowledged and produces no write strobe.
- R4: Each later byte of a write is acknowledged and raises `reg_wr_en` for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wr_data` equal to the received byte.
- R5: The pointer increases by one after every byte written (R4) or read (R6), and it goes from 19 to 0.
- R6: In a read, each byte is taken from `reg_rd_data` for the current pointer and sent MSB first. Bytes continue for as long as the master acknowledges them.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START.
- R8: A repeated START (a START with no STOP before it) returns the slave to address matching in the middle of a transfer.
- R9: While `pwr_fail` is high, the transfer in progress ends, the pointer is cleared to 0, SDA is released, and no write strobe or acknowledge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous to clk |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 5 | Register pointer, used for both reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Register contents at `reg_addr` |

## Verification
The write strobe and the pointer update come from the same SCL falling edge. In one cycle the register file must take the old pointer while the pointer moves on, and at index 19 that move is a wrap to 0. The bench provokes this with a full 20-byte write sweep and with a write that starts at index 18. It judges the result by reading every location back through the bus and comparing it with values computed arithmetically. A second collision sets `pwr_fail` against an open write transfer: the next byte must be refused, the write count must not change and the pointer must read back as 0.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } i2c_rf_st_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rf_ptr.sv
module i2c_rf_ptr #(
   parameter int N = 20,
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [7:0]   load_val,
   input  logic         inc,
   output logic [W-1:0] ptr
);
   logic [W-1:0] ptr_next_inc;

   generate
      if ((1 << W) == N) begin : g_pow2
         assign ptr_next_inc = ptr + W'(1);
      end else begin : g_cmp
         assign ptr_next_inc = (ptr == W'(N - 1)) ? '0 : ptr + W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (clr)
         ptr <= '0;
      else if (load)
         ptr <= (32'(load_val) < N) ? load_val[W-1:0] : '0;
      else if (inc)
         ptr <= ptr_next_inc;
   end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         NUM_REGS    = 20,
   parameter int         SYNC_STAGES = 2,
   localparam int        PTR_W       = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   output logic             reg_wr_en,
   output logic [7:0]       reg_wr_data,
   input  logic [7:0]       reg_rd_data
);
   import i2c_rf_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS < 2 || PTR_W > 8) begin : g_bad_regs
         $error("NUM_REGS must lie in 2..256");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_rf_st_e st;
   logic [3:0] bitcnt;
   logic [7:0] sh;
   logic       rw, first, ack_ok;
   logic       ev_ok, byte_end, ptr_load, ptr_inc;

   // bus events count only when no condition or power fault overrides them
   assign ev_ok       = ~pwr_fail & ~start_det & ~stop_det;
   assign byte_end    = ev_ok & scl_fall & (bitcnt == 4'd8);
   assign ptr_load    = byte_end & (st == ST_RX) & first;
   assign reg_wr_en   = byte_end & (st == ST_RX) & ~first;
   assign ptr_inc     = reg_wr_en | (byte_end & (st == ST_TX));
   assign reg_wr_data = sh;

   i2c_rf_ptr #(.N(NUM_REGS), .W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pwr_fail),
      .load    (ptr_load),
      .load_val(sh),
      .inc     (ptr_inc),
      .ptr     (reg_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         bitcnt <= '0;
         sh     <= '0;
         rw     <= 1'b0;
         first  <= 1'b0;
         ack_ok <= 1'b0;
         sda_oe <= 1'b0;
      end else if (pwr_fail) begin
         st     <= ST_IDLE;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         st     <= ST_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (st)
            ST_ADDR, ST_RX: begin
               if (scl_rise) begin
                  sh     <= {sh[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  if (st == ST_RX) begin
                     sda_oe <= 1'b1;
                     st     <= ST_RACK;
                  end else if (sh[7:1] == DEV_ADDR) begin
                     sda_oe <= 1'b1;
                     rw     <= sh[0];
                     st     <= ST_AACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     sh     <= reg_rd_data;
                     sda_oe <= ~reg_rd_data[7];
                     st     <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     first  <= 1'b1;
                     st     <= ST_RX;
                  end
               end
            end
            ST_RACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  first  <= 1'b0;
                  bitcnt <= '0;
                  st     <= ST_RX;
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     st     <= ST_TACK;
                  end else begin
                     sh     <= {sh[6:0], 1'b0};
                     sda_oe <= ~sh[6];
                  end
               end
            end
            ST_TACK: begin
               if (scl_rise) begin
                  ack_ok <= ~sda_s;
               end else if (scl_fall) begin
                  if (ack_ok) begin
                     sh     <= reg_rd_data;
                     sda_oe <= ~reg_rd_data[7];
                     bitcnt <= '0;
                     st     <= ST_TX;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
   parameter int NUM_REGS = 20,
   parameter int PTR_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_fail,
   input logic             sda_oe,
   input logic [PTR_W-1:0] reg_addr,
   input logic             reg_wr_en
);
   // R9: a power fault clears the pointer and releases the line one cycle later
   assert_pwrfail_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (reg_addr == '0 && !sda_oe));

   // R9: no write strobe while the supply is bad
   assert_pwrfail_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |-> !reg_wr_en);

   // R5: pointer advances by one after a written byte, wrapping at the end
   assert_write_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !pwr_fail) |=>
         (reg_addr == (($past(reg_addr) == PTR_W'(NUM_REGS - 1)) ? '0 : $past(reg_addr) + PTR_W'(1))));

   // R3: the pointer never leaves the register space
   assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(reg_addr) < NUM_REGS);

   // R4: the write strobe lasts exactly one cycle
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);
endmodule

bind i2c_regfile_slave i2c_rf_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_fail (pwr_fail),
   .sda_oe   (sda_oe),
   .reg_addr (reg_addr),
   .reg_wr_en(reg_wr_en)
);

// File: tb/i2c_regfile_slave_tb.sv
`timescale 1ns/1ps
module i2c_regfile_slave_tb;
   localparam int Q  = 10;
   localparam int NR = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_fail = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe, reg_wr_en;
   logic [4:0] reg_addr;
   logic [7:0] reg_wr_data, reg_rd_data;
   logic sda_line;

   logic [7:0] mem [NR];
   logic [7:0] expm [NR];
   int wr_cnt = 0;
   int total = 0;
   int passed = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_regfile_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_fail   (pwr_fail),
      .scl_i      (m_scl),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NR; i++) mem[i] <= '0;
         wr_cnt <= 0;
      end else if (reg_wr_en) begin
         if (reg_addr < 5'(NR)) mem[reg_addr] <= reg_wr_data;
         wr_cnt <= wr_cnt + 1;
      end
   end
   assign reg_rd_data = (reg_addr < 5'(NR)) ? mem[reg_addr] : 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (ok) passed++;
      else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq();
         m_scl = 1'b1; wq(); wq();
         m_scl = 1'b0;
      end
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      ack = ~sda_line;
      wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         m_scl = 1'b1; wq();
         b[i] = sda_line;
         wq();
         m_scl = 1'b0;
      end
      m_sda = give_ack ? 1'b0 : 1'b1; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
      m_sda = 1'b1;
      if (!give_ack) chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", passed, total);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] b;
      int w0;
      for (int i = 0; i < NR; i++) expm[i] = 8'h00;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      wq();
      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(reg_wr_en == 1'b0, "R1 reg_wr_en", reg_wr_en, 0);
      chk(reg_addr == 5'd0, "R1 reg_addr", reg_addr, 0);

      // R2 foreign address ignored, data after it not acked
      bus_start();
      send_byte(8'hD2, a); chk(a == 1'b0, "R2 no ack for D2", a, 0);
      send_byte(8'h03, a); chk(a == 1'b0, "R2 stays released", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'hD3, a); chk(a == 1'b0, "R2 no ack for D3", a, 0);
      bus_stop();
      chk(wr_cnt == 0, "R2 no writes", wr_cnt, 0);

      // R3 R4 R5 write sweep over the whole space
      bus_start();
      send_byte(8'hD0, a); chk(a == 1'b1, "R2 ack for D0", a, 1);
      send_byte(8'h00, a); chk(a == 1'b1, "R3 pointer byte acked", a, 1);
      for (int i = 0; i < NR; i++) begin
         send_byte(pat(i), a); expm[i] = pat(i);
         chk(a == 1'b1, "R4 data acked", a, 1);
      end
      bus_stop();
      chk(wr_cnt == NR, "R4 one strobe per byte", wr_cnt, NR);
      chk(reg_addr == 5'd0, "R5 wrap after 19", reg_addr, 0);

      // R6 R8 read back 22 bytes through a repeated START
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'h00, a);
      bus_rstart();
      send_byte(8'hD1, a); chk(a == 1'b1, "R8 R2 ack for D1 after repeated START", a, 1);
      for (int i = 0; i < 22; i++) begin
         recv_byte(i != 21, b);
         chk(b == expm[i % NR], "R6 read data", b, expm[i % NR]);
      end
      bus_stop();
      chk(reg_addr == 5'd2, "R5 read wrap", reg_addr, 2);

      // R5 write across the wrap point
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd18, a);
      for (int i = 0; i < 4; i++) begin
         send_byte(8'hA0 + 8'(i), a);
         expm[(18 + i) % NR] = 8'hA0 + 8'(i);
      end
      bus_rstart();
      send_byte(8'hD0, a);
      send_byte(8'd18, a);
      bus_rstart();
      send_byte(8'hD1, a);
      for (int i = 0; i < 4; i++) begin
         recv_byte(i != 3, b);
         chk(b == expm[(18 + i) % NR], "R5 wrapped write", b, expm[(18 + i) % NR]);
      end
      bus_stop();

      // R6 read continues from the pointer left by the last read
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk(b == expm[2], "R6 continued read", b, expm[2]);
      chk(reg_addr == 5'd3, "R5 increment after read", reg_addr, 3);

      // R3 out of range pointer loads 0
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd25, a);
      bus_stop();
      chk(reg_addr == 5'd0, "R3 out of range pointer", reg_addr, 0);

      // R8 repeated START in a write
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd5, a);
      send_byte(8'h5A, a); expm[5] = 8'h5A;
      bus_rstart();
      send_byte(8'hD0, a); chk(a == 1'b1, "R8 address matched again", a, 1);
      send_byte(8'd7, a);
      send_byte(8'hC3, a); expm[7] = 8'hC3;
      bus_rstart();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      bus_stop();
      chk(b == expm[8], "R8 pointer reloaded", b, expm[8]);
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd5, a);
      bus_rstart();
      send_byte(8'hD1, a);
      for (int i = 0; i < 3; i++) begin
         recv_byte(i != 2, b);
         chk(b == expm[5 + i], "R8 data after repeated START", b, expm[5 + i]);
      end
      bus_stop();

      // R9 power fail during a write
      w0 = wr_cnt;
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd9, a);
      pwr_fail = 1'b1;
      wq();
      chk(reg_addr == 5'd0, "R9 pointer cleared", reg_addr, 0);
      chk(sda_oe == 1'b0, "R9 line released", sda_oe, 0);
      send_byte(8'hEE, a); chk(a == 1'b0, "R9 byte refused", a, 0);
      bus_stop();
      bus_start();
      send_byte(8'hD0, a); chk(a == 1'b0, "R9 address ignored", a, 0);
      send_byte(8'd3, a);
      send_byte(8'hEE, a);
      bus_stop();
      chk(wr_cnt == w0, "R9 no writes", wr_cnt, w0);
      pwr_fail = 1'b0;
      wq();
      bus_start();
      send_byte(8'hD1, a); chk(a == 1'b1, "R9 recovers", a, 1);
      for (int i = 0; i < 4; i++) begin
         recv_byte(i != 3, b);
         chk(b == expm[i], "R9 pointer 0 and memory kept", b, expm[i]);
      end
      bus_stop();

      done = 1'b1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end
endmodule